// File: doc/BRIEF.md
# Video Timing Reference Flag Generator

This block sits behind a serial-to-parallel video receiver. It watches a stream of 10-bit video words that arrive one per word-rate clock. It finds the four-word timing references embedded in that stream. A reference is a preamble of one all-ones word and two all-zeros words, followed by a fourth word that carries the line flags.

The words come out of the block after a short fixed delay. That delay lets two active-low flags line up with the words they describe:
- `ref_flag_n` is low on every one of the four words of a reference.
- `eav_flag_n` pulses low for one clock on the fourth word when that word marks the end of active video.

Two static inputs set the mode of operation:
- `composite_sel` chooses composite operation. In that mode the end-of-active-video output is held inactive.
- `narrow_sel` selects 8-bit sample comparison. In that mode only the upper eight bits of each word take part in preamble matching.

Top module: `tref_flag_gen`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge clears the delay line and makes `vid_out` zero and both flags high after that edge. Both flags stay high until a complete four-word reference has entered after reset. A reference cut by a reset is never flagged.
- R2: A word sampled on `vid_in` at clock edge j appears on `vid_out` after edge j+3 and is held until the next edge.
- R3: For a reference 3FF, 000, 000, W (W any value), `ref_flag_n` is low during exactly the four output cycles in which `vid_out` carries those four words, and high otherwise.
- R4: With `composite_sel` = 0, a fourth word with bit 6 equal to 1 marks end of active video. `eav_flag_n` is then low for exactly the one output cycle that carries that fourth word.
- R5: With `composite_sel` = 0, a fourth word with bit 6 equal to 0 still drives the four-cycle `ref_flag_n` marking, and `eav_flag_n` stays high.
- R6: With `composite_sel` = 1 (held since the previous clock), `eav_flag_n` is high in every cycle. `ref_flag_n` still marks 3FF, 000, 000 followed by any word.
- R7: With `narrow_sel` = 1, only bits 9:2 are compared, so 3FD, 002, 001, W is recognised. With `narrow_sel` = 0 all ten bits must match and that same stream is not recognised.
- R8: An incomplete preamble (3FF, 000 followed by a non-zero word, or 000, 000 without a preceding 3FF) produces no low level on either flag.
- R9: In a run of several 3FF words followed by 000, 000, W, only the last 3FF and the three words after it are marked. The earlier 3FF words keep `ref_flag_n` high.
- R10: When the fourth word of one reference is itself 3FF and starts a second reference, `ref_flag_n` stays low over all seven words. `eav_flag_n` pulses on each fourth word whose bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_in | input | 10 | Incoming parallel video word |
| composite_sel | input | 1 | 1 = composite operation, 0 = component |
| narrow_sel | input | 1 | 1 = compare upper 8 bits only, 0 = all 10 bits |
| vid_out | output | 10 | Video word delayed to align with the flags |
| ref_flag_n | output | 1 | Low on every word of a timing reference |
| eav_flag_n | output | 1 | Low for one cycle on the fourth word of an end-of-active-video reference |

## Verification
The bench builds the block with its default parameters. These are a 10-bit word, an 8-bit narrow comparison, a three-word lookahead and the line flag at bit 6. With these values, a single elaboration can switch between full-width and narrow matching at run time. It can also switch between component and composite modes at run time.

With a three-word lookahead, a reference can be chained onto the fourth word of the one before it, so the long merged flag runs are exercised. The repeated-3FF streams and the reset-in-mid-preamble streams reach the restart and the partial-match corners.

// File: rtl/tref_pkg.sv
package tref_pkg;

    // Result of looking at one complete window of words
    typedef struct packed {
        logic hit;     // full preamble followed by a fourth word
        logic line_end; // fourth word flags end of active video
    } tref_hit_t;

    localparam tref_hit_t TREF_NO_HIT = '{hit: 1'b0, line_end: 1'b0};

endpackage

// File: rtl/tref_delay.sv
module tref_delay #(
    parameter int W   = 10,
    parameter int LAG = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [W-1:0]         din,
    output logic [LAG-1:0][W-1:0] taps,
    output logic [W-1:0]         dout
);
    localparam int DEPTH = LAG + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stage;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.stage = '0;
        end else begin
            st_d.stage[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.stage[i] = st_q.stage[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < LAG; g++) begin : g_tap
        assign taps[g] = st_q.stage[g];
    end

    assign dout = st_q.stage[DEPTH-1];

endmodule

// File: rtl/tref_match.sv
module tref_match
    import tref_pkg::*;
#(
    parameter int W     = 10,
    parameter int CMP_W = 8,
    parameter int LAG   = 3,
    parameter int H_BIT = 6
) (
    input  logic [W-1:0]          newest,
    input  logic [LAG-1:0][W-1:0] older,
    input  logic                  narrow_sel,
    output tref_hit_t             result
);
    localparam logic [W-1:0] NARROW_MASK = {{CMP_W{1'b1}}, {(W-CMP_W){1'b0}}};
    localparam logic [W-1:0] FULL_MASK   = '1;

    logic [W-1:0]   mask;
    logic [LAG-1:0] word_ok;

    assign mask = narrow_sel ? NARROW_MASK : FULL_MASK;

    // older[LAG-1] must be all ones, every younger preamble word all zeros
    for (genvar g = 0; g < LAG; g++) begin : g_cmp
        if (g == LAG - 1) begin : g_ones
            assign word_ok[g] = ((older[g] ^ FULL_MASK) & mask) == '0;
        end else begin : g_zero
            assign word_ok[g] = (older[g] & mask) == '0;
        end
    end

    always_comb begin
        result          = TREF_NO_HIT;
        result.hit      = &word_ok;
        result.line_end = (&word_ok) & newest[H_BIT];
    end

endmodule

// File: rtl/tref_flags.sv
module tref_flags
    import tref_pkg::*;
#(
    parameter int LAG = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  tref_hit_t cur,
    input  logic      composite_sel,
    output logic      ref_flag_n,
    output logic      eav_flag_n
);
    typedef struct packed {
        tref_hit_t [LAG-1:0] seen;  // seen[i]: window result i+1 edges ago
        logic                ref_n;
        logic                eav_n;
    } flg_state_t;

    flg_state_t st_d, st_q;
    logic       any_recent;

    always_comb begin
        any_recent = cur.hit;
        for (int i = 0; i < LAG; i++) begin
            any_recent = any_recent | st_q.seen[i].hit;
        end
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.seen  = '0;
            st_d.ref_n = 1'b1;
            st_d.eav_n = 1'b1;
        end else begin
            st_d.seen[0] = cur;
            for (int i = 1; i < LAG; i++) begin
                st_d.seen[i] = st_q.seen[i-1];
            end
            st_d.ref_n = ~any_recent;
            st_d.eav_n = ~(st_q.seen[LAG-1].hit & st_q.seen[LAG-1].line_end
                           & ~composite_sel);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ref_flag_n = st_q.ref_n;
    assign eav_flag_n = st_q.eav_n;

endmodule

// File: rtl/tref_flag_gen.sv
module tref_flag_gen
    import tref_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int CMP_W  = 8,
    parameter int LAG    = 3,
    parameter int H_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] vid_in,
    input  logic              composite_sel,
    input  logic              narrow_sel,
    output logic [WORD_W-1:0] vid_out,
    output logic              ref_flag_n,
    output logic              eav_flag_n
);
    logic [LAG-1:0][WORD_W-1:0] hist;
    tref_hit_t                  win_res;

    tref_delay #(.W(WORD_W), .LAG(LAG)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (vid_in),
        .taps (hist),
        .dout (vid_out)
    );

    tref_match #(.W(WORD_W), .CMP_W(CMP_W), .LAG(LAG), .H_BIT(H_BIT)) u_match (
        .newest     (vid_in),
        .older      (hist),
        .narrow_sel (narrow_sel),
        .result     (win_res)
    );

    tref_flags #(.LAG(LAG)) u_flags (
        .clk           (clk),
        .rst           (rst),
        .cur           (win_res),
        .composite_sel (composite_sel),
        .ref_flag_n    (ref_flag_n),
        .eav_flag_n    (eav_flag_n)
    );

endmodule

// File: rtl/tref_flag_gen_chk.sv
module tref_flag_gen_chk #(
    parameter int WORD_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] vid_in,
    input logic              composite_sel,
    input logic [WORD_W-1:0] vid_out,
    input logic              ref_flag_n,
    input logic              eav_flag_n
);
    logic [3:0] low_run_q;
    logic [2:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run_q <= '0;
            since_q   <= '0;
        end else begin
            if (!ref_flag_n) begin
                if (low_run_q != 4'hF) low_run_q <= low_run_q + 4'd1;
            end else begin
                low_run_q <= '0;
            end
            if (since_q != 3'd7) since_q <= since_q + 3'd1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ref_flag_n && eav_flag_n && vid_out == '0));

    a_r2_word_delay: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 3'd4) |-> (vid_out == $past(vid_in, 4)));

    a_r3_ref_run_len: assert property (@(posedge clk) disable iff (rst)
        (ref_flag_n && low_run_q != 4'd0) |-> (low_run_q >= 4'd4));

    a_r4_eav_single: assert property (@(posedge clk) disable iff (rst)
        !eav_flag_n |=> eav_flag_n);

    a_r4_eav_inside_ref: assert property (@(posedge clk) disable iff (rst)
        !eav_flag_n |-> !ref_flag_n);

    a_r4_eav_on_fourth: assert property (@(posedge clk) disable iff (rst)
        !eav_flag_n |-> (low_run_q >= 4'd3));

    a_r6_composite_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(composite_sel) |-> eav_flag_n);

endmodule

bind tref_flag_gen tref_flag_gen_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .vid_in        (vid_in),
    .composite_sel (composite_sel),
    .vid_out       (vid_out),
    .ref_flag_n    (ref_flag_n),
    .eav_flag_n    (eav_flag_n)
);

// File: tb/tb_tref_flag_gen.sv
`timescale 1ns/1ps
module tb_tref_flag_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] vid_in = 10'h200;
    logic       composite_sel = 1'b0;
    logic       narrow_sel = 1'b0;
    logic [9:0] vid_out;
    logic       ref_flag_n;
    logic       eav_flag_n;

    always #4 clk = ~clk;

    tref_flag_gen dut (
        .clk           (clk),
        .rst           (rst),
        .vid_in        (vid_in),
        .composite_sel (composite_sel),
        .narrow_sel    (narrow_sel),
        .vid_out       (vid_out),
        .ref_flag_n    (ref_flag_n),
        .eav_flag_n    (eav_flag_n)
    );

    int checks = 0;
    int failures = 0;
    int ref_lows = 0;
    int eav_lows = 0;
    int cycles = 0;
    bit model_live = 0;
    bit done = 0;

    // behavioural reference model
    logic [9:0] hist[$];
    int         mq[$];      // 0 none, 1 reference, 2 end-of-active reference
    logic [9:0] exp_vid;
    logic       exp_ref;
    logic       exp_eav;

    function automatic bit peq(logic [9:0] a, logic [9:0] b, bit nar);
        return nar ? (a[9:2] == b[9:2]) : (a == b);
    endfunction

    always @(posedge clk) begin
        int m;
        if (rst) begin
            hist.delete();
            mq.delete();
            exp_vid = 10'h000;
            exp_ref = 1'b1;
            exp_eav = 1'b1;
        end else begin
            hist.push_front(vid_in);
            if (hist.size() > 4) void'(hist.pop_back());
            m = 0;
            if (hist.size() == 4 && peq(hist[3], 10'h3FF, narrow_sel)
                && peq(hist[2], 10'h000, narrow_sel) && peq(hist[1], 10'h000, narrow_sel))
                m = hist[0][6] ? 2 : 1;
            mq.push_front(m);
            if (mq.size() > 4) void'(mq.pop_back());
            exp_vid = (hist.size() == 4) ? hist[3] : 10'h000;
            exp_ref = 1'b1;
            foreach (mq[i]) if (mq[i] != 0) exp_ref = 1'b0;
            exp_eav = !(mq.size() == 4 && mq[3] == 2 && !composite_sel);
        end
        model_live = 1;
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #2;
        cycles++;
        if (model_live && !done) begin
            check("R2 vid_out", vid_out, exp_vid);
            check("R3 ref_flag_n", ref_flag_n, exp_ref);
            check("R4 eav_flag_n", eav_flag_n, exp_eav);
            if (!ref_flag_n) ref_lows++;
            if (!eav_flag_n) eav_lows++;
        end
    end

    task automatic send(logic [9:0] w);
        vid_in = w;
        @(negedge clk);
    endtask

    task automatic flush();
        for (int i = 0; i < 8; i++) send(10'h200);
    endtask

    task automatic clear_counts();
        ref_lows = 0;
        eav_lows = 0;
    endtask

    task automatic check_counts(string tag, int er, int ee);
        check({tag, " ref low cycles"}, ref_lows, er);
        check({tag, " eav low cycles"}, eav_lows, ee);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        vid_in = 10'h3FF;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 vid_out in reset", vid_out, 0);
        check("R1 ref_flag_n in reset", ref_flag_n, 1);
        check("R1 eav_flag_n in reset", eav_flag_n, 1);
        rst = 1'b0;
        vid_in = 10'h200;
        clear_counts();
        flush();
        check_counts("R1 idle after reset", 0, 0);

        // R3 R4 component end-of-active reference
        clear_counts();
        send(10'h3FF); send(10'h000); send(10'h000); send(10'h274);
        flush();
        check_counts("R3 R4 eav reference", 4, 1);

        // R5 start-of-active reference
        clear_counts();
        send(10'h3FF); send(10'h000); send(10'h000); send(10'h200);
        flush();
        check_counts("R5 sav reference", 4, 0);

        // R6 composite mode
        composite_sel = 1'b1;
        flush();
        clear_counts();
        send(10'h3FF); send(10'h000); send(10'h000); send(10'h274);
        flush();
        check_counts("R6 composite", 4, 0);
        composite_sel = 1'b0;
        flush();

        // R7 narrow comparison
        narrow_sel = 1'b1;
        flush();
        clear_counts();
        send(10'h3FD); send(10'h002); send(10'h001); send(10'h2D8);
        flush();
        check_counts("R7 narrow match", 4, 1);
        narrow_sel = 1'b0;
        flush();
        clear_counts();
        send(10'h3FD); send(10'h002); send(10'h001); send(10'h2D8);
        flush();
        check_counts("R7 wide rejects", 0, 0);

        // R8 partial preambles
        clear_counts();
        send(10'h3FF); send(10'h000); send(10'h005); send(10'h200);
        send(10'h3FF); send(10'h200);
        send(10'h000); send(10'h000); send(10'h274);
        flush();
        check_counts("R8 partial", 0, 0);

        // R9 repeated all-ones words
        clear_counts();
        send(10'h3FF); send(10'h3FF); send(10'h3FF);
        send(10'h000); send(10'h000); send(10'h274);
        flush();
        check_counts("R9 repeated 3FF", 4, 1);

        // R10 chained references
        clear_counts();
        send(10'h3FF); send(10'h000); send(10'h000);
        send(10'h3FF); send(10'h000); send(10'h000); send(10'h274);
        flush();
        check_counts("R10 chained", 7, 2);

        // R1 reset cuts a preamble
        clear_counts();
        send(10'h3FF); send(10'h000);
        rst = 1'b1;
        send(10'h000); send(10'h000);
        rst = 1'b0;
        send(10'h000); send(10'h274);
        flush();
        check_counts("R1 reset mid preamble", 0, 0);

        finish_run();
    end

    initial begin
        wait (cycles > 20000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
        finish_run();
    end

endmodule